// File: doc/BRIEF.md
# Extended-Mode Legacy Display Register Override

This block keeps the three legacy display register files (sequencer, graphics
controller and CRT controller) together with a small bank of extended display
registers: a mode-on flag, horizontal resolution, vertical resolution, colour
depth and line pitch. While the extended mode is on, every accepted write to a
legacy register or to an extended register marks the block as pending. On the
next clock edge a fixed set of legacy fields is recomputed from the extended
geometry, so the legacy view always describes the linear framebuffer mode in use.

Software reaches the legacy files through one indexed port, with a file select,
an index, write data and a registered read. The extended registers sit behind a
second indexed port. A write to a legacy register passes through a per-index mask
of writable bits. When the protect bit of the CRT controller is set, that file's
registers 0 to 6 are locked, and register 7 accepts only its bit 4. While the
extended mode is off, the block is a plain register store.

Top module: `vbe_vga_regs`

## Requirements
- R1: After synchronous reset, every legacy and extended register reads 0 and the extended mode is off.
- R2: While the mode flag (extended index 0, bit 0) is clear, a legacy write stores `wdata & mask` and the stored value does not change afterwards. Masks: sequencer 1 = 0x3D, 2 = 0x0F, 4 = 0x0E; graphics 5 = 0x7B, 6 = 0x0F; CRT indices 0x00 to 0x18 = 0xFF.
- R3: When CRT register 0x11 bit 7 is set, writes to CRT registers 0 to 6 are ignored, and a write to CRT register 7 changes only its bit 4.
- R4: After an override, graphics register 6 has bits 3:2 = 01 and bit 0 set, and CRT register 0x17 has bits 1:0 set.
- R5: After an override, CRT register 0x01 = (xres >> 3) − 1 and CRT register 0x13 = pitch >> 3 (low 8 bits in both).
- R6: After an override, with h = yres − 1: CRT register 0x12 = h[7:0], CRT register 7 bit 1 = h[8] and CRT register 7 bit 6 = h[9].
- R7: After an override, CRT register 0x18 = 0xFF and CRT register 7 bit 4 is set. CRT register 9 becomes (old | 0x40) & 0x60.
- R8: With depth = 4, an override clears sequencer register 1 bit 3 and writes 00 to graphics register 5 bits 6:5.
- R9: With any other depth, an override sets sequencer register 4 bit 3, sets sequencer register 2 bits 3:0 and writes 10 to graphics register 5 bits 6:5.
- R10: While the mode is on, the override is applied on the edge after any in-range legacy write (a locked-out CRT 0 to 6 write excepted) and after any write to extended indices 0 to 4. A read issued in the cycle after the write returns the overridden value.
- R11: When a legacy write coincides with a pending override, the override is applied first and the write lands on top of it, and a read in that cycle returns the overridden pre-write value. When a legacy write and an extended write arrive together, the next override uses the new extended value.
- R12: Extended indices are 0 = mode flag (bit 0), 1 = xres, 2 = yres, 3 = depth, 4 = pitch. They read back as written one cycle after a read request, and any other index reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lg_we | input | 1 | Legacy register write strobe |
| lg_re | input | 1 | Legacy register read request |
| lg_file | input | 2 | Legacy file select: 0 sequencer, 1 graphics, 2 CRT |
| lg_idx | input | 8 | Legacy register index |
| lg_wdata | input | 8 | Legacy write data |
| lg_rdata | output | 8 | Legacy read data, valid the cycle after lg_re |
| ex_we | input | 1 | Extended register write strobe |
| ex_re | input | 1 | Extended register read request |
| ex_idx | input | 3 | Extended register index |
| ex_wdata | input | 16 | Extended write data |
| ex_rdata | output | 16 | Extended read data, valid the cycle after ex_re |

## Verification
Two things can fall on the same clock edge: a pending override and a new legacy write, and likewise a legacy write and an extended geometry write. The first case is provoked by two back-to-back writes to graphics register 6 with a read of that register issued alongside the second write. The read must return the overridden value, and a later read must show the override again on top of the second write. The second case drives a CRT width write together with a new vertical resolution. It is judged by the width register holding its extended-derived value and by the height fields reflecting the new resolution.

// File: rtl/vbe_ovr_pkg.sv
package vbe_ovr_pkg;

    localparam int REG_W = 8;
    localparam int EXT_W = 16;

    typedef enum logic [1:0] {
        FILE_SEQ  = 2'd0,
        FILE_GFX  = 2'd1,
        FILE_CRT  = 2'd2,
        FILE_NONE = 2'd3
    } lfile_e;

    typedef enum logic [2:0] {
        EX_MODE  = 3'd0,
        EX_XRES  = 3'd1,
        EX_YRES  = 3'd2,
        EX_DEPTH = 3'd3,
        EX_PITCH = 3'd4
    } xidx_e;

    typedef struct packed {
        logic             on;
        logic [EXT_W-1:0] xres;
        logic [EXT_W-1:0] yres;
        logic [EXT_W-1:0] depth;
        logic [EXT_W-1:0] pitch;
    } xregs_t;

    // legacy register indices touched by the override
    localparam int SEQ_CLK   = 1;
    localparam int SEQ_PLANE = 2;
    localparam int SEQ_MEM   = 4;
    localparam int GFX_MODE  = 5;
    localparam int GFX_MISC  = 6;
    localparam int CRT_HDISP = 1;
    localparam int CRT_OVF   = 7;
    localparam int CRT_SCAN  = 9;
    localparam int CRT_LOCK  = 17;
    localparam int CRT_VEND  = 18;
    localparam int CRT_PITCH = 19;
    localparam int CRT_MODE  = 23;
    localparam int CRT_LCMP  = 24;
    localparam int CRT_LOCKED_TOP = 7;

    function automatic logic [REG_W-1:0] seq_mask(input logic [7:0] idx);
        case (idx)
            8'd0:    return 8'h03;
            8'd1:    return 8'h3D;
            8'd2:    return 8'h0F;
            8'd3:    return 8'h3F;
            8'd4:    return 8'h0E;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] gfx_mask(input logic [7:0] idx);
        case (idx)
            8'd0, 8'd1, 8'd2, 8'd6, 8'd7: return 8'h0F;
            8'd3:    return 8'h1F;
            8'd4:    return 8'h03;
            8'd5:    return 8'h7B;
            8'd8:    return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] crt_mask(input logic [7:0] idx);
        return (idx <= 8'd24) ? 8'hFF : 8'h00;
    endfunction

endpackage

// File: rtl/vbe_lreg_bank.sv
module vbe_lreg_bank
    import vbe_ovr_pkg::*;
#(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      apply,
    input  logic [N-1:0][REG_W-1:0]   ovr,
    input  logic                      we,
    input  logic [IW-1:0]             idx,
    input  logic [REG_W-1:0]          wdata,
    input  logic [REG_W-1:0]          wmask,
    output logic [N-1:0][REG_W-1:0]   q,
    output logic [N-1:0][REG_W-1:0]   view
);

    // the value each entry holds once a pending override has been applied
    assign view = apply ? ovr : q;

    for (genvar i = 0; i < N; i++) begin : g_ent
        logic [REG_W-1:0] r;
        always_ff @(posedge clk) begin
            if (rst) begin
                r <= '0;
            end else if (we && idx == IW'(i)) begin
                r <= (view[i] & ~wmask) | (wdata & wmask);
            end else begin
                r <= view[i];
            end
        end
        assign q[i] = r;
    end

endmodule

// File: rtl/vbe_ovr_engine.sv
module vbe_ovr_engine
    import vbe_ovr_pkg::*;
#(
    parameter int SN = 8,
    parameter int GN = 16,
    parameter int CN = 32
) (
    input  logic [SN-1:0][REG_W-1:0] sr_i,
    input  logic [GN-1:0][REG_W-1:0] gr_i,
    input  logic [CN-1:0][REG_W-1:0] cr_i,
    input  logic [EXT_W-1:0]         xres,
    input  logic [EXT_W-1:0]         yres,
    input  logic [EXT_W-1:0]         depth,
    input  logic [EXT_W-1:0]         pitch,
    output logic [SN-1:0][REG_W-1:0] sr_o,
    output logic [GN-1:0][REG_W-1:0] gr_o,
    output logic [CN-1:0][REG_W-1:0] cr_o
);

    logic [9:0]       hlast;
    logic [1:0]       shift;
    logic [REG_W-1:0] ovf;

    always_comb begin
        sr_o  = sr_i;
        gr_o  = gr_i;
        cr_o  = cr_i;
        hlast = 10'(yres - 16'd1);

        // graphics, memory window, no CGA addressing
        gr_o[GFX_MISC] = (gr_i[GFX_MISC] & 8'hF3) | 8'h05;
        cr_o[CRT_MODE] = cr_i[CRT_MODE] | 8'h03;

        // geometry
        cr_o[CRT_PITCH] = 8'(pitch >> 3);
        cr_o[CRT_HDISP] = 8'((xres >> 3) - 16'd1);
        cr_o[CRT_VEND]  = hlast[7:0];

        ovf    = cr_i[CRT_OVF] & 8'hBD;
        ovf[1] = hlast[8];
        ovf[6] = hlast[9];
        ovf[4] = 1'b1;
        cr_o[CRT_OVF] = ovf;

        // split-screen line pushed to the last line, double scan off
        cr_o[CRT_LCMP] = 8'hFF;
        cr_o[CRT_SCAN] = (cr_i[CRT_SCAN] | 8'h40) & 8'h60;

        if (depth == 16'd4) begin
            shift = 2'd0;
            sr_o[SEQ_CLK][3] = 1'b0;
        end else begin
            shift = 2'd2;
            sr_o[SEQ_MEM][3]      = 1'b1;
            sr_o[SEQ_PLANE][3:0]  = 4'hF;
        end
        gr_o[GFX_MODE][6:5] = shift;
    end

endmodule

// File: rtl/vbe_xreg_file.sv
module vbe_xreg_file
    import vbe_ovr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic             re,
    input  logic [2:0]       idx,
    input  logic [EXT_W-1:0] wdata,
    output logic [EXT_W-1:0] rdata,
    output xregs_t           x,
    output logic             trig
);

    assign trig = we && (idx <= EX_PITCH);

    always_ff @(posedge clk) begin
        if (rst) begin
            x <= '0;
        end else if (we) begin
            case (xidx_e'(idx))
                EX_MODE:  x.on    <= wdata[0];
                EX_XRES:  x.xres  <= wdata;
                EX_YRES:  x.yres  <= wdata;
                EX_DEPTH: x.depth <= wdata;
                EX_PITCH: x.pitch <= wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (re) begin
            case (xidx_e'(idx))
                EX_MODE:  rdata <= {{(EXT_W-1){1'b0}}, x.on};
                EX_XRES:  rdata <= x.xres;
                EX_YRES:  rdata <= x.yres;
                EX_DEPTH: rdata <= x.depth;
                EX_PITCH: rdata <= x.pitch;
                default:  rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/vbe_vga_regs.sv
module vbe_vga_regs
    import vbe_ovr_pkg::*;
#(
    parameter int SN = 8,
    parameter int GN = 16,
    parameter int CN = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lg_we,
    input  logic             lg_re,
    input  logic [1:0]       lg_file,
    input  logic [7:0]       lg_idx,
    input  logic [7:0]       lg_wdata,
    output logic [7:0]       lg_rdata,
    input  logic             ex_we,
    input  logic             ex_re,
    input  logic [2:0]       ex_idx,
    input  logic [15:0]      ex_wdata,
    output logic [15:0]      ex_rdata
);

    localparam int SIW = $clog2(SN);
    localparam int GIW = $clog2(GN);
    localparam int CIW = $clog2(CN);
    localparam logic [7:0] SN8 = 8'(SN);
    localparam logic [7:0] GN8 = 8'(GN);
    localparam logic [7:0] CN8 = 8'(CN);

    xregs_t ext_x;
    logic   ex_trig;
    logic   ovr_pend;
    logic   apply;

    logic [SN-1:0][REG_W-1:0] sr_q, sr_view, sr_ovr;
    logic [GN-1:0][REG_W-1:0] gr_q, gr_view, gr_ovr;
    logic [CN-1:0][REG_W-1:0] cr_q, cr_view, cr_ovr;

    logic sr_hit, gr_hit, cr_hit, cr_lockout;
    logic [REG_W-1:0] cr_wmask;

    // --- address decode ---
    assign sr_hit = (lfile_e'(lg_file) == FILE_SEQ) && (lg_idx < SN8);
    assign gr_hit = (lfile_e'(lg_file) == FILE_GFX) && (lg_idx < GN8);
    assign cr_hit = (lfile_e'(lg_file) == FILE_CRT) && (lg_idx < CN8);

    // --- CRT write protection ---
    always_comb begin
        cr_lockout = 1'b0;
        cr_wmask   = crt_mask(lg_idx);
        if (cr_view[CRT_LOCK][7] && lg_idx <= 8'(CRT_LOCKED_TOP)) begin
            if (lg_idx == 8'(CRT_LOCKED_TOP)) begin
                cr_wmask = cr_wmask & 8'h10;
            end else begin
                cr_wmask   = 8'h00;
                cr_lockout = 1'b1;
            end
        end
    end

    // --- override sequencing ---
    assign apply = ovr_pend && ext_x.on;

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr_pend <= 1'b0;
        end else begin
            ovr_pend <= (lg_we && (sr_hit || gr_hit || (cr_hit && !cr_lockout)))
                        || ex_trig;
        end
    end

    vbe_xreg_file u_xregs (
        .clk   (clk),
        .rst   (rst),
        .we    (ex_we),
        .re    (ex_re),
        .idx   (ex_idx),
        .wdata (ex_wdata),
        .rdata (ex_rdata),
        .x     (ext_x),
        .trig  (ex_trig)
    );

    vbe_ovr_engine #(.SN(SN), .GN(GN), .CN(CN)) u_engine (
        .sr_i  (sr_q),
        .gr_i  (gr_q),
        .cr_i  (cr_q),
        .xres  (ext_x.xres),
        .yres  (ext_x.yres),
        .depth (ext_x.depth),
        .pitch (ext_x.pitch),
        .sr_o  (sr_ovr),
        .gr_o  (gr_ovr),
        .cr_o  (cr_ovr)
    );

    vbe_lreg_bank #(.N(SN)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .apply (apply),
        .ovr   (sr_ovr),
        .we    (lg_we && sr_hit),
        .idx   (lg_idx[SIW-1:0]),
        .wdata (lg_wdata),
        .wmask (seq_mask(lg_idx)),
        .q     (sr_q),
        .view  (sr_view)
    );

    vbe_lreg_bank #(.N(GN)) u_gfx (
        .clk   (clk),
        .rst   (rst),
        .apply (apply),
        .ovr   (gr_ovr),
        .we    (lg_we && gr_hit),
        .idx   (lg_idx[GIW-1:0]),
        .wdata (lg_wdata),
        .wmask (gfx_mask(lg_idx)),
        .q     (gr_q),
        .view  (gr_view)
    );

    vbe_lreg_bank #(.N(CN)) u_crt (
        .clk   (clk),
        .rst   (rst),
        .apply (apply),
        .ovr   (cr_ovr),
        .we    (lg_we && cr_hit),
        .idx   (lg_idx[CIW-1:0]),
        .wdata (lg_wdata),
        .wmask (cr_wmask),
        .q     (cr_q),
        .view  (cr_view)
    );

    // --- registered legacy read, returns post-override values ---
    always_ff @(posedge clk) begin
        if (rst) begin
            lg_rdata <= '0;
        end else if (lg_re) begin
            if (sr_hit)      lg_rdata <= sr_view[lg_idx[SIW-1:0]];
            else if (gr_hit) lg_rdata <= gr_view[lg_idx[GIW-1:0]];
            else if (cr_hit) lg_rdata <= cr_view[lg_idx[CIW-1:0]];
            else             lg_rdata <= '0;
        end
    end

endmodule

// File: rtl/vbe_vga_regs_chk.sv
module vbe_vga_regs_chk
    import vbe_ovr_pkg::*;
#(
    parameter int SN = 8,
    parameter int GN = 16,
    parameter int CN = 32
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     lg_we,
    input logic [1:0]               lg_file,
    input logic [7:0]               lg_idx,
    input logic                     ex_we,
    input logic                     x_on,
    input logic                     apply,
    input logic [15:0]              depth,
    input logic [7:0]               lg_rdata,
    input logic [15:0]              ex_rdata,
    input logic [SN-1:0][REG_W-1:0] sr_q,
    input logic [GN-1:0][REG_W-1:0] gr_q,
    input logic [CN-1:0][REG_W-1:0] cr_q
);

    a_r1_reset_reads_zero: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lg_rdata == 8'h00 && ex_rdata == 16'h0000));

    a_r2_idle_when_off: assert property (@(posedge clk) disable iff (rst)
        (!x_on && !lg_we && !ex_we) |=>
            ($stable(sr_q) && $stable(gr_q) && $stable(cr_q)));

    a_r3_locked_low_crt: assert property (@(posedge clk) disable iff (rst)
        (lg_we && lg_file == 2'd2 && lg_idx < 8'd7 && cr_q[CRT_LOCK][7] && !apply)
            |=> $stable(cr_q[6:0]));

    a_r4_mode_fields: assert property (@(posedge clk) disable iff (rst)
        (apply && !lg_we) |=>
            (gr_q[GFX_MISC][3:2] == 2'b01 && gr_q[GFX_MISC][0] &&
             cr_q[CRT_MODE][1:0] == 2'b11));

    a_r7_line_compare: assert property (@(posedge clk) disable iff (rst)
        (apply && !lg_we) |=>
            (cr_q[CRT_LCMP] == 8'hFF && cr_q[CRT_OVF][4] &&
             cr_q[CRT_SCAN][6] && cr_q[CRT_SCAN][7] == 1'b0 &&
             cr_q[CRT_SCAN][4:0] == 5'd0));

    a_r9_chain_planes: assert property (@(posedge clk) disable iff (rst)
        (apply && !lg_we && depth != 16'd4) |=>
            (sr_q[SEQ_MEM][3] && sr_q[SEQ_PLANE][3:0] == 4'hF &&
             gr_q[GFX_MODE][6:5] == 2'b10));

endmodule

bind vbe_vga_regs vbe_vga_regs_chk #(.SN(SN), .GN(GN), .CN(CN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .lg_we    (lg_we),
    .lg_file  (lg_file),
    .lg_idx   (lg_idx),
    .ex_we    (ex_we),
    .x_on     (ext_x.on),
    .apply    (apply),
    .depth    (ext_x.depth),
    .lg_rdata (lg_rdata),
    .ex_rdata (ex_rdata),
    .sr_q     (sr_q),
    .gr_q     (gr_q),
    .cr_q     (cr_q)
);

// File: tb/vbe_vga_regs_tb.sv
module vbe_vga_regs_tb_top;

    localparam logic [1:0] SEQ = 2'd0;
    localparam logic [1:0] GFX = 2'd1;
    localparam logic [1:0] CRT = 2'd2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lg_we = 1'b0, lg_re = 1'b0;
    logic [1:0]  lg_file = '0;
    logic [7:0]  lg_idx = '0, lg_wdata = '0;
    logic [7:0]  lg_rdata;
    logic        ex_we = 1'b0, ex_re = 1'b0;
    logic [2:0]  ex_idx = '0;
    logic [15:0] ex_wdata = '0;
    logic [15:0] ex_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    vbe_vga_regs dut_i (
        .clk(clk), .rst(rst),
        .lg_we(lg_we), .lg_re(lg_re), .lg_file(lg_file), .lg_idx(lg_idx),
        .lg_wdata(lg_wdata), .lg_rdata(lg_rdata),
        .ex_we(ex_we), .ex_re(ex_re), .ex_idx(ex_idx),
        .ex_wdata(ex_wdata), .ex_rdata(ex_rdata)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic lg_wr(input logic [1:0] f, input logic [7:0] i, input logic [7:0] d);
        @(negedge clk);
        lg_we = 1'b1; lg_file = f; lg_idx = i; lg_wdata = d;
        @(posedge clk); #1;
        lg_we = 1'b0;
    endtask

    task automatic lg_chk(input logic [1:0] f, input logic [7:0] i,
                          input logic [7:0] exp, input string tag);
        @(negedge clk);
        lg_re = 1'b1; lg_file = f; lg_idx = i;
        @(posedge clk); #1;
        lg_re = 1'b0;
        @(negedge clk);
        check(tag, {8'h00, lg_rdata}, {8'h00, exp});
    endtask

    task automatic ex_wr(input logic [2:0] i, input logic [15:0] d);
        @(negedge clk);
        ex_we = 1'b1; ex_idx = i; ex_wdata = d;
        @(posedge clk); #1;
        ex_we = 1'b0;
    endtask

    task automatic ex_chk(input logic [2:0] i, input logic [15:0] exp, input string tag);
        @(negedge clk);
        ex_re = 1'b1; ex_idx = i;
        @(posedge clk); #1;
        ex_re = 1'b0;
        @(negedge clk);
        check(tag, ex_rdata, exp);
    endtask

    task automatic t_reset;
        lg_chk(SEQ, 8'd0, 8'h00, "R1 seq0 after reset");
        lg_chk(GFX, 8'd6, 8'h00, "R1 gfx6 after reset");
        lg_chk(CRT, 8'd7, 8'h00, "R1 crt7 after reset");
        ex_chk(3'd0, 16'h0000, "R1 mode flag after reset");
        ex_chk(3'd1, 16'h0000, "R1 xres after reset");
    endtask

    task automatic t_plain_store;
        lg_wr(GFX, 8'd6, 8'hFF);  lg_chk(GFX, 8'd6, 8'h0F, "R2 gfx6 masked");
        lg_wr(SEQ, 8'd4, 8'h07);  lg_chk(SEQ, 8'd4, 8'h06, "R2 seq4 masked");
        lg_wr(SEQ, 8'd1, 8'hFF);  lg_chk(SEQ, 8'd1, 8'h3D, "R2 seq1 masked");
        lg_wr(GFX, 8'd5, 8'hFF);  lg_chk(GFX, 8'd5, 8'h7B, "R2 gfx5 masked");
        lg_wr(CRT, 8'd9, 8'hFF);  lg_chk(CRT, 8'd9, 8'hFF, "R2 crt9 untouched when off");
        lg_wr(CRT, 8'd24, 8'h12); lg_chk(CRT, 8'd24, 8'h12, "R2 crt24 untouched when off");
        lg_chk(CRT, 8'd23, 8'h00, "R2 crt23 not forced when off");
    endtask

    task automatic t_protect;
        lg_wr(CRT, 8'd17, 8'h80);
        lg_wr(CRT, 8'd1, 8'h55);  lg_chk(CRT, 8'd1, 8'h00, "R3 crt1 locked");
        lg_wr(CRT, 8'd7, 8'hFF);  lg_chk(CRT, 8'd7, 8'h10, "R3 crt7 only bit4");
        lg_wr(CRT, 8'd17, 8'h00);
        lg_wr(CRT, 8'd7, 8'h00);  lg_chk(CRT, 8'd7, 8'h00, "R3 crt7 unlocked");
    endtask

    task automatic t_ext_regs;
        ex_wr(3'd1, 16'd640);
        ex_wr(3'd2, 16'd480);
        ex_wr(3'd3, 16'd8);
        ex_wr(3'd4, 16'd1280);
        ex_chk(3'd1, 16'd640,  "R12 xres readback");
        ex_chk(3'd4, 16'd1280, "R12 pitch readback");
        ex_chk(3'd5, 16'h0000, "R12 unused index");
        ex_wr(3'd0, 16'h0001);
        ex_chk(3'd0, 16'h0001, "R12 mode flag readback");
    endtask

    task automatic t_enable_override;
        lg_chk(GFX, 8'd6,  8'h07, "R4 gfx6 forced");
        lg_chk(CRT, 8'd23, 8'h03, "R4 crt23 low bits");
        lg_chk(CRT, 8'd19, 8'hA0, "R5 crt19 pitch");
        lg_chk(CRT, 8'd1,  8'h4F, "R5 crt1 width");
        lg_chk(CRT, 8'd18, 8'hDF, "R6 crt18 height low");
        lg_chk(CRT, 8'd7,  8'h12, "R6 crt7 height bits and R7 bit4");
        lg_chk(CRT, 8'd24, 8'hFF, "R7 crt24 line compare");
        lg_chk(CRT, 8'd9,  8'h60, "R7 crt9 double scan off");
        lg_chk(SEQ, 8'd4,  8'h0E, "R9 seq4 chain bit");
        lg_chk(SEQ, 8'd2,  8'h0F, "R9 seq2 planes");
        lg_chk(GFX, 8'd5,  8'h5B, "R9 gfx5 shift 2");
    endtask

    task automatic t_rewrite;
        lg_wr(GFX, 8'd6, 8'h00);  lg_chk(GFX, 8'd6, 8'h05, "R10 gfx6 re-forced");
        lg_wr(CRT, 8'd1, 8'h11);  lg_chk(CRT, 8'd1, 8'h4F, "R10 crt1 re-forced");
        ex_wr(3'd1, 16'd800);     lg_chk(CRT, 8'd1, 8'h63, "R10 crt1 after xres write");
    endtask

    task automatic t_depth4;
        ex_wr(3'd3, 16'd4);
        lg_chk(SEQ, 8'd1, 8'h35, "R8 seq1 double line off");
        lg_chk(GFX, 8'd5, 8'h1B, "R8 gfx5 shift 0");
        lg_chk(SEQ, 8'd4, 8'h0E, "R8 seq4 left alone");
    endtask

    task automatic t_overlap;
        lg_wr(GFX, 8'd6, 8'h00);
        @(negedge clk);
        lg_we = 1'b1; lg_re = 1'b1; lg_file = GFX; lg_idx = 8'd6; lg_wdata = 8'h08;
        @(posedge clk); #1;
        lg_we = 1'b0; lg_re = 1'b0;
        @(negedge clk);
        check("R11 read with write sees override", {8'h00, lg_rdata}, 16'h0005);
        lg_chk(GFX, 8'd6, 8'h05, "R11 write then re-forced");
        @(negedge clk);
        lg_we = 1'b1; lg_file = CRT; lg_idx = 8'd1; lg_wdata = 8'h22;
        ex_we = 1'b1; ex_idx = 3'd2; ex_wdata = 16'd600;
        @(posedge clk); #1;
        lg_we = 1'b0; ex_we = 1'b0;
        lg_chk(CRT, 8'd1,  8'h63, "R11 crt1 with concurrent ext write");
        lg_chk(CRT, 8'd18, 8'h57, "R11 crt18 new height");
        lg_chk(CRT, 8'd7,  8'h50, "R11 crt7 new height bits");
    endtask

    task automatic t_disable;
        ex_wr(3'd0, 16'h0000);
        ex_chk(3'd0, 16'h0000, "R2 mode flag cleared");
        lg_wr(GFX, 8'd6, 8'h00);  lg_chk(GFX, 8'd6, 8'h00, "R2 gfx6 kept when off");
        lg_wr(CRT, 8'd24, 8'h12); lg_chk(CRT, 8'd24, 8'h12, "R2 crt24 kept when off");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_plain_store();
        t_protect();
        t_ext_regs();
        t_enable_override();
        t_rewrite();
        t_depth4();
        t_overlap();
        t_disable();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule